// File: doc/BRIEF.md
# Asynchronous SRAM Request Sequencer

This block sits between a simple internal request bus and a 32K x 8 asynchronous static RAM with active-low select, write strobe and output enable. Each accepted request becomes a fixed sequence of pin phases. A read keeps the part selected with its outputs enabled for an access wait and then captures the byte. A write sets up the address and data, pulses the write strobe, holds the data and then releases the bus. Every transaction ends with a deselected turnaround gap before the next one is taken.

Each phase length is a parameter counted in clock cycles. The read wait is derived from the clock period and the memory access time. The pin sequences follow the hazard rules of such memories. The address moves only while the part is deselected. Output enable stays high for the whole of a write, so the short write pulse is legal. The controller's data drivers are never on while the memory may be driving the bus, and they are never on in the cycle right after it stopped.

The bidirectional data bus appears as three plain ports: a drive value, a drive enable and the sensed bus value. The pad ring combines them.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after reset, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: req_ready is 1 exactly when no transaction is in progress. A request is taken on a clock edge where req_valid and req_ready are both 1. The address, data and flag are captured only on that edge, and changes to them at other times have no effect on the memory pins. mem_addr changes only on an accepting edge.
- R3: A read (req_write = 0) drives, from the cycle after acceptance, mem_cs_n = 0, mem_oe_n = 0, mem_we_n = 1 and mem_dq_oe = 0 with the request address for ACC cycles. ACC = ceil(ACC_PS / CLK_PS) + 1, which is 2 at the defaults. This is followed by TURN cycles with all three strobes at 1 and drivers off. req_ready then returns to 1.
- R4: rd_valid is 1 for exactly one cycle per read and never for a write. It rises in the first turnaround cycle, with rd_data equal to the bus value sampled on the edge that ends the last access cycle.
- R5: A write (req_write = 1) drives, from the cycle after acceptance, SETUP cycles of cs_n = 0, we_n = 1, oe_n = 1 with data driven. It then drives WP cycles with we_n = 0 and HOLD cycles with we_n = 1, still selected and driven, then TURN cycles deselected with drivers off.
- R6: mem_addr is unchanged between any two consecutive cycles in which mem_cs_n is 0, so it never moves while select and write strobe are both low.
- R7: mem_oe_n is 0 only in read access cycles. Whenever it is 0, mem_we_n is 1 and mem_dq_oe is 0.
- R8: mem_dq_oe is 1 only when mem_oe_n is 1 in that cycle and in the cycle before it, so the controller and the memory never drive the bus together.
- R9: mem_we_n is 0 only while mem_cs_n is 0 and mem_dq_oe has been 1 since the previous cycle. In the cycle after mem_we_n rises, the data is still driven and the part is still selected.
- R10: A read returns the byte most recently written to that address through the block, including the lowest (0x0000) and highest (0x7FFF) locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request taken when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 8 | Returned read byte |
| mem_addr | output | 15 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Value the controller drives onto the data bus |
| mem_dq_oe | output | 1 | Controller data driver enable |
| mem_dq_in | input | 8 | Sensed data bus value |

## Verification
The bench applies the following traffic:
- Isolated reads and writes separated by idle gaps, which show the exact phase lengths and the point where the ready signal returns.
- Back-to-back requests held valid while the controller is busy, which separate a correct handshake from one that accepts early or drops a request.
- Every direction change (write after read, read after write), which exposes driver and output-enable overlap through the bus model's contention flag.
- Corner addresses and complementary data patterns, plus request fields scrambled right after acceptance, which show whether the address and data are captured only at acceptance.
- A pseudo-random mix of operations over a small address window, which compares read-back values against the bench's own record of writes.

The SRAM model returns a wrong byte until a full cycle of read access has elapsed. A capture taken too early in the read therefore shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_ACC,
    PH_WR_SETUP,
    PH_WR_PULSE,
    PH_WR_HOLD,
    PH_TURN
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } pins_t;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Access time rounded up to whole cycles, plus one cycle of capture margin.
  function automatic int unsigned access_wait_cycles(int unsigned clk_ps, int unsigned acc_ps);
    return ceil_div(acc_ps, clk_ps) + 1;
  endfunction

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned phase_len(phase_e ph, int unsigned acc, int unsigned setup,
                                            int unsigned wp, int unsigned hold,
                                            int unsigned turn);
    case (ph)
      PH_RD_ACC:   return acc;
      PH_WR_SETUP: return setup;
      PH_WR_PULSE: return wp;
      PH_WR_HOLD:  return hold;
      PH_TURN:     return turn;
      default:     return 1;
    endcase
  endfunction

  // Pin levels that belong to each phase.
  function automatic pins_t pins_for(phase_e ph);
    pins_t p;
    p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    case (ph)
      PH_RD_ACC:   begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
      PH_WR_SETUP: begin p.cs_n = 1'b0; p.drive = 1'b1; end
      PH_WR_PULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
      PH_WR_HOLD:  begin p.cs_n = 1'b0; p.drive = 1'b1; end
      default:     ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ACC_CYC   = 2,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WP_CYC    = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned TURN_CYC  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_write,
  output phase_e phase,
  output phase_e phase_next,
  output logic   phase_end
);

  localparam int unsigned LMAX =
    max_of(max_of(max_of(ACC_CYC, SETUP_CYC), max_of(WP_CYC, HOLD_CYC)), TURN_CYC);
  localparam int CNT_W = (LMAX < 2) ? 1 : $clog2(LMAX);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign phase_end  = cnt_zero && (ph_q != PH_IDLE);
  assign phase      = ph_q;
  assign phase_next = ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:     if (start) ph_d = start_write ? PH_WR_SETUP : PH_RD_ACC;
      PH_RD_ACC:   if (cnt_zero) ph_d = PH_TURN;
      PH_WR_SETUP: if (cnt_zero) ph_d = PH_WR_PULSE;
      PH_WR_PULSE: if (cnt_zero) ph_d = PH_WR_HOLD;
      PH_WR_HOLD:  if (cnt_zero) ph_d = PH_TURN;
      PH_TURN:     if (cnt_zero) ph_d = PH_IDLE;
      default:     ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_d != ph_q)
        cnt_q <= CNT_W'(phase_len(ph_d, ACC_CYC, SETUP_CYC, WP_CYC, HOLD_CYC, TURN_CYC) - 1);
      else if (!cnt_zero)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3 R5: a busy phase is never left before its counter has run out.
  p_phase_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && !cnt_zero) |=> (ph_q == $past(ph_q)));

  // R2: leaving idle only on a start request.
  p_idle_until_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !start) |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_next,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  pins_t nxt;
  assign nxt = pins_for(phase_next);

  // Strobes are registered so the pins never glitch on a state decode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      mem_cs_n  <= nxt.cs_n;
      mem_we_n  <= nxt.we_n;
      mem_oe_n  <= nxt.oe_n;
      mem_dq_oe <= nxt.drive;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rd_valid <= capture;
      if (capture) rd_data <= mem_dq_in;
    end
  end

  p_addr_still_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  p_oe_only_reading_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  p_drive_after_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  p_strobe_inside_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_dq_oe && $past(mem_dq_oe)));

  p_hold_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mem_we_n) && mem_we_n) |-> (mem_dq_oe && !mem_cs_n));

  p_valid_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned ACC_PS    = 10000,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WP_CYC    = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned ACC_CYC = access_wait_cycles(CLK_PS, ACC_PS);

  phase_e phase, phase_next;
  logic   phase_end;
  logic   accept;
  logic   capture;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = phase_end && (phase == PH_RD_ACC);

  sram_phase_seq #(
    .ACC_CYC  (ACC_CYC),
    .SETUP_CYC(SETUP_CYC),
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_write(req_write),
    .phase      (phase),
    .phase_next (phase_next),
    .phase_end  (phase_end)
  );

  sram_pin_drive #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_next(phase_next),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  p_ready_means_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_addr_moves_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(accept));

endmodule

// File: tb/sram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb;

  localparam int CLK_PS = 10000;
  localparam int ACC_PS = 10000;
  localparam int ACC    = (ACC_PS + CLK_PS - 1) / CLK_PS + 1;
  localparam int SETUP  = 1;
  localparam int WP     = 3;
  localparam int HOLD   = 2;
  localparam int TURN   = 2;

  localparam logic [2:0] TG_IDLE = 3'd0;
  localparam logic [2:0] TG_RD   = 3'd1;
  localparam logic [2:0] TG_WR   = 3'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_seq_ctrl #(
    .CLK_PS(CLK_PS), .ACC_PS(ACC_PS), .SETUP_CYC(SETUP), .WP_CYC(WP),
    .HOLD_CYC(HOLD), .TURN_CYC(TURN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic void chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endfunction

  function automatic string tag_name(logic [2:0] tg);
    case (tg)
      TG_RD:   return "R3";
      TG_WR:   return "R5";
      default: return "R2";
    endcase
  endfunction

  // ---------------- behavioural asynchronous SRAM ----------------
  logic [7:0]  sram    [0:32767];
  logic [7:0]  ref_mem [0:32767];
  int          rd_held = 0;
  logic        prev_strobe = 1'b0;
  logic [14:0] prev_addr = '0;
  logic        mem_drive;

  assign mem_drive = !mem_cs_n && mem_we_n && !mem_oe_n;
  assign mem_dq_in = mem_dq_oe ? mem_dq_out :
                     (mem_drive ? ((rd_held >= 1) ? sram[mem_addr] : 8'hEE) : 8'h00);

  initial begin
    for (int i = 0; i < 32768; i++) begin
      sram[i]    = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
  end

  // ---------------- cycle reference model ----------------
  typedef struct packed {
    logic        cs_n;
    logic        we_n;
    logic        oe_n;
    logic        drv;
    logic        rdv;
    logic [14:0] addr;
    logic [7:0]  data;
    logic [2:0]  tg;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t mk(logic cs, logic we, logic oe, logic dr, logic rv,
                              logic [14:0] a, logic [7:0] d, logic [2:0] tg);
    exp_t e;
    e.cs_n = cs; e.we_n = we; e.oe_n = oe; e.drv = dr; e.rdv = rv;
    e.addr = a; e.data = d; e.tg = tg;
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_t e;
      bit busy;
      logic strobe;
      // memory model hazards
      strobe = !mem_cs_n && !mem_we_n;
      chk(!(mem_dq_oe && mem_drive), "R8", "bus contention", 1, 0);
      if (prev_strobe && strobe)
        chk(mem_addr == prev_addr, "R6", "address moved under strobe", int'(mem_addr), int'(prev_addr));
      if (strobe) begin
        chk(mem_dq_oe, "R9", "strobe without drive", 0, 1);
        if (mem_dq_oe) sram[mem_addr] = mem_dq_out;
      end
      prev_strobe = strobe;
      prev_addr   = mem_addr;
      rd_held     = mem_drive ? rd_held + 1 : 0;

      // reference compare
      busy = (exp_q.size() > 0);
      if (busy) e = exp_q.pop_front();
      else      e = mk(1, 1, 1, 0, 0, '0, '0, TG_IDLE);
      chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == {e.cs_n, e.we_n, e.oe_n, e.drv},
          tag_name(e.tg), "cs/we/oe/drive",
          int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), int'({e.cs_n, e.we_n, e.oe_n, e.drv}));
      if (!e.cs_n)
        chk(mem_addr == e.addr, "R2", "mem_addr", int'(mem_addr), int'(e.addr));
      if (e.drv)
        chk(mem_dq_out == e.data, "R5", "write data", int'(mem_dq_out), int'(e.data));
      chk(req_ready == !busy, "R2", "req_ready", int'(req_ready), int'(!busy));
      chk(rd_valid == e.rdv, "R4", "rd_valid", int'(rd_valid), int'(e.rdv));
      if (e.rdv)
        chk(rd_data == e.data, "R10", "rd_data", int'(rd_data), int'(e.data));

      if (req_valid && !busy) begin
        if (req_write) begin
          ref_mem[req_addr] = req_wdata;
          for (int i = 0; i < SETUP; i++) exp_q.push_back(mk(0, 1, 1, 1, 0, req_addr, req_wdata, TG_WR));
          for (int i = 0; i < WP; i++)    exp_q.push_back(mk(0, 0, 1, 1, 0, req_addr, req_wdata, TG_WR));
          for (int i = 0; i < HOLD; i++)  exp_q.push_back(mk(0, 1, 1, 1, 0, req_addr, req_wdata, TG_WR));
          for (int i = 0; i < TURN; i++)  exp_q.push_back(mk(1, 1, 1, 0, 0, req_addr, req_wdata, TG_WR));
        end else begin
          for (int i = 0; i < ACC; i++) exp_q.push_back(mk(0, 1, 0, 0, 0, req_addr, '0, TG_RD));
          for (int i = 0; i < TURN; i++)
            exp_q.push_back(mk(1, 1, 1, 0, (i == 0), req_addr, ref_mem[req_addr], TG_RD));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    bit [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while reset is held
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready} == 6'b111001,
        "R1", "reset pins", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready}), 6'b111001);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready} == 6'b111001,
        "R1", "pins after reset", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready}), 6'b111001);
    @(posedge clk);
    #1;

    // isolated operations with gaps, corner addresses
    issue(1, 15'h0000, 8'hA5); gap(4);
    issue(1, 15'h7FFF, 8'h3C); gap(4);
    issue(0, 15'h0000, 8'h00); gap(4);
    issue(0, 15'h7FFF, 8'h00); gap(3);
    issue(0, 15'h1234, 8'h00); gap(3);

    // back-to-back, every direction change
    issue(1, 15'h0010, 8'hFF);
    issue(1, 15'h0011, 8'h00);
    issue(0, 15'h0010, 8'h00);
    issue(1, 15'h0010, 8'h55);
    issue(0, 15'h0010, 8'h00);
    issue(0, 15'h0011, 8'h00);
    issue(0, 15'h7FFF, 8'h00);
    drain();

    // pseudo-random mix in a small window
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      issue(lfsr[0], {11'h000, lfsr[4:1]}, lfsr[15:8]);
      if (lfsr[20]) gap(int'(lfsr[23:21]));
    end
    drain();
    gap(3);
    finish_run();
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

endmodule